// File: doc/BRIEF.md
# Controller memory buffer window configuration

This block holds the configuration state for a host-visible memory buffer window in a storage controller. Software programs a 64-bit window control register through a simple register-write port (4-byte or 8-byte writes). From that value the block decides whether two read-only description registers are visible, and whether the window is live and at which base address. A live base is accepted only if the whole buffer fits below the top of the 64-bit address space. Otherwise a sticky status bit records the rejected base.

A combinational decoder compares any access address with the active window. It returns a hit flag and the byte offset into the buffer. The state is held in a three-state machine. `ST_HIDDEN` means the description registers read zero and the window is off. `ST_VISIBLE` means the description registers are populated and the window is off. `ST_ACTIVE` means the registers are populated and the window decodes. Every low-half control write leaves the current state and evaluates the merged register value. A clear register-enable bit goes to `ST_HIDDEN`. A set register-enable bit with a clear memory-enable bit, or with a base that wraps, goes to `ST_VISIBLE`. Both bits set with a base that fits goes to `ST_ACTIVE`. With the `LEGACY` parameter set, reset enters `ST_ACTIVE`, and the window sits at the externally supplied bus base address.

Top module: `cmb_cfg_regs`

## Requirements
- R1: With `LEGACY`=0, reset leaves `ctl_q`=0, `sts_q`=0, `sz_q`=0, `loc_q`=0, `win_en`=0 and `hit`=0.
- R2: The control register sits at offset 0x050 (low half) and 0x054 (high half). An 8-byte write at 0x050 (`wr_size8`=1) replaces all 64 bits. A 4-byte write at 0x050 replaces bits 31:0 only. A write at 0x054 loads `wr_data[31:0]` into bits 63:32.
- R3: `cap_o` is 1 exactly when `SIZE_MB` is nonzero. When it is 0, all control writes are ignored.
- R4: A low-half write with bit 0 (register enable) set makes `sz_q` = {SIZE_MB[19:0], 4'd2, 3'b000, 5'b11101}. The low five bits are, from bit 0 upward: submission queues, completion queues, lists, read data and write data. It also makes `loc_q` = `BAR_IND` in bits 2:0, with the rest zero.
- R5: A low-half write with bit 0 clear forces `sz_q`=0 and `loc_q`=0, and turns the window off.
- R6: A low-half write with bits 0 and 1 (memory enable) set takes as its candidate base the merged 64-bit register value with bits below `CBA_SHIFT` cleared. If base + SIZE_MB·2^20 < 2^64, the write latches that base into `win_base` and sets `win_en`=1.
- R7: If the candidate base plus the buffer size reaches 2^64 or more, `sts_q[0]` is set and `win_en` stays 0. `sts_q[0]` stays set until reset.
- R8: Every low-half write first disables the window. A write that does not reach R6's success case leaves `win_en`=0, even if the window was live before.
- R9: `hit`=1 exactly when `win_en`=1 and `win_base` <= `acc_addr` < `win_base` + size. While `hit`=1, `hit_off` = `acc_addr` − `win_base`.
- R10: With `LEGACY`=1, reset populates `sz_q` and `loc_q` as in R4 and sets `win_en`=1, and the active base is `bar_base`.
- R11: Writes to the location register (0x038), the size register (0x03C), or the high half (0x054) change neither `sz_q`, `loc_q` nor `win_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 64 | Write data |
| wr_size8 | input | 1 | 1 = 8-byte write, 0 = 4-byte write |
| bar_base | input | 64 | Bus-assigned base used in legacy mode |
| acc_addr | input | 64 | Address to decode against the window |
| cap_o | output | 1 | Buffer-supported capability bit |
| ctl_q | output | 64 | Window control register |
| loc_q | output | 32 | Location register |
| sz_q | output | 32 | Size register |
| sts_q | output | 32 | Status register (bit 0 = invalid base) |
| win_en | output | 1 | Window live |
| win_base | output | 64 | Active window base |
| hit | output | 1 | Access address falls in the window |
| hit_off | output | 64 | Offset of the access into the buffer |

## Verification
A wrong state shows on `sz_q`, `loc_q` and `win_en` in the first cycle after the offending write. Examples are a stale `ST_ACTIVE` after a failed base, or `ST_HIDDEN` after an enable. Because `hit` is combinational from that state, a decode probe in the same cycle exposes a wrong latched base. The probes sit exactly at the first and last byte of the window, one byte past each end, and at bases whose end lands exactly on, or just below, the top of the address space. A sticky-bit fault appears on `sts_q` after the next successful activation.

// File: rtl/cmb_pkg.sv
`timescale 1ns/1ps
package cmb_pkg;
    typedef enum logic [1:0] {
        ST_HIDDEN  = 2'd0,
        ST_VISIBLE = 2'd1,
        ST_ACTIVE  = 2'd2
    } cmb_state_e;

    localparam logic [11:0] OFS_LOC    = 12'h038;
    localparam logic [11:0] OFS_SZ     = 12'h03C;
    localparam logic [11:0] OFS_CTL_LO = 12'h050;
    localparam logic [11:0] OFS_CTL_HI = 12'h054;

    localparam int CTL_REG_EN   = 0;
    localparam int CTL_MEM_EN   = 1;
    localparam int STS_BAD_BASE = 0;
    localparam int MB_SHIFT     = 20;

    // size word: [31:12] count, [11:8] unit, [4:0] support flags
    function automatic logic [31:0] sz_word(input int unsigned mb);
        logic [31:0] v;
        v = {mb[19:0], 4'd2, 3'b000, 5'b11101};
        return v;
    endfunction
endpackage

// File: rtl/cmb_ctl_fsm.sv
`timescale 1ns/1ps
module cmb_ctl_fsm
    import cmb_pkg::*;
#(
    parameter int          CBA_SHIFT  = 12,
    parameter logic [63:0] SIZE_BYTES = 64'h0040_0000,
    parameter bit          LEGACY     = 1'b0,
    parameter bit          CAP        = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] wr_addr,
    input  logic [63:0] wr_data,
    input  logic        wr_size8,
    output cmb_state_e  state_q,
    output logic [63:0] ctl_q,
    output logic [31:0] sts_q,
    output logic [63:0] base_q
);
    localparam cmb_state_e RST_STATE = LEGACY ? ST_ACTIVE : ST_HIDDEN;

    logic        lo_wr, hi_wr, wraps;
    logic [63:0] merged, cand_base;
    logic [64:0] end_sum;
    cmb_state_e  eval_state, state_d;

    assign lo_wr     = wr_en && CAP && (wr_addr == OFS_CTL_LO);
    assign hi_wr     = wr_en && CAP && (wr_addr == OFS_CTL_HI);
    assign merged    = wr_size8 ? wr_data : {ctl_q[63:32], wr_data[31:0]};
    assign cand_base = (merged >> CBA_SHIFT) << CBA_SHIFT;
    assign end_sum   = {1'b0, cand_base} + {1'b0, SIZE_BYTES};
    assign wraps     = end_sum[64];

    always_comb begin
        if (!merged[CTL_REG_EN])
            eval_state = ST_HIDDEN;
        else if (!merged[CTL_MEM_EN] || wraps)
            eval_state = ST_VISIBLE;
        else
            eval_state = ST_ACTIVE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HIDDEN:  if (lo_wr) state_d = eval_state;
            ST_VISIBLE: if (lo_wr) state_d = eval_state;
            ST_ACTIVE:  if (lo_wr) state_d = eval_state;
            default:    state_d = RST_STATE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            sts_q  <= '0;
            base_q <= '0;
        end else begin
            if (lo_wr) begin
                ctl_q <= merged;
                if (merged[CTL_REG_EN] && merged[CTL_MEM_EN]) begin
                    if (wraps) sts_q[STS_BAD_BASE] <= 1'b1;
                    else       base_q <= cand_base;
                end
            end else if (hi_wr) begin
                ctl_q[63:32] <= wr_data[31:0];
            end
        end
    end
endmodule

// File: rtl/cmb_id_regs.sv
`timescale 1ns/1ps
module cmb_id_regs
    import cmb_pkg::*;
#(
    parameter int          SIZE_MB = 4,
    parameter logic [2:0]  BAR_IND = 3'd2
) (
    input  cmb_state_e  state_q,
    output logic [31:0] loc_q,
    output logic [31:0] sz_q,
    output logic        win_en
);
    localparam logic [31:0] SZ_VAL  = sz_word(SIZE_MB);
    localparam logic [31:0] LOC_VAL = {29'd0, BAR_IND};

    always_comb begin
        loc_q  = '0;
        sz_q   = '0;
        win_en = 1'b0;
        unique case (state_q)
            ST_HIDDEN: ;
            ST_VISIBLE: begin
                loc_q = LOC_VAL;
                sz_q  = SZ_VAL;
            end
            ST_ACTIVE: begin
                loc_q  = LOC_VAL;
                sz_q   = SZ_VAL;
                win_en = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cmb_win_decode.sv
`timescale 1ns/1ps
module cmb_win_decode #(
    parameter logic [63:0] SIZE_BYTES = 64'h0040_0000
) (
    input  logic        en,
    input  logic [63:0] base,
    input  logic [63:0] addr,
    output logic        hit,
    output logic [63:0] off
);
    logic [64:0] lim;
    assign lim = {1'b0, base} + {1'b0, SIZE_BYTES};
    assign hit = en && (addr >= base) && ({1'b0, addr} < lim);
    assign off = addr - base;
endmodule

// File: rtl/cmb_cfg_regs.sv
`timescale 1ns/1ps
module cmb_cfg_regs
    import cmb_pkg::*;
#(
    parameter int         SIZE_MB   = 4,
    parameter int         CBA_SHIFT = 12,
    parameter logic [2:0] BAR_IND   = 3'd2,
    parameter bit         LEGACY    = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] wr_addr,
    input  logic [63:0] wr_data,
    input  logic        wr_size8,
    input  logic [63:0] bar_base,
    input  logic [63:0] acc_addr,
    output logic        cap_o,
    output logic [63:0] ctl_q,
    output logic [31:0] loc_q,
    output logic [31:0] sz_q,
    output logic [31:0] sts_q,
    output logic        win_en,
    output logic [63:0] win_base,
    output logic        hit,
    output logic [63:0] hit_off
);
    localparam logic [63:0] SIZE_BYTES = 64'(SIZE_MB) << MB_SHIFT;
    localparam bit          CAP        = (SIZE_MB != 0);

    cmb_state_e  state_q;
    logic [63:0] prog_base;

    assign cap_o = CAP;

    cmb_ctl_fsm #(
        .CBA_SHIFT(CBA_SHIFT), .SIZE_BYTES(SIZE_BYTES),
        .LEGACY(LEGACY), .CAP(CAP)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size8(wr_size8), .state_q(state_q),
        .ctl_q(ctl_q), .sts_q(sts_q), .base_q(prog_base)
    );

    cmb_id_regs #(.SIZE_MB(SIZE_MB), .BAR_IND(BAR_IND)) u_id (
        .state_q(state_q), .loc_q(loc_q), .sz_q(sz_q), .win_en(win_en)
    );

    generate
        if (LEGACY) begin : g_legacy_base
            assign win_base = bar_base;
        end else begin : g_prog_base
            assign win_base = prog_base;
        end
    endgenerate

    cmb_win_decode #(.SIZE_BYTES(SIZE_BYTES)) u_dec (
        .en(win_en), .base(win_base), .addr(acc_addr),
        .hit(hit), .off(hit_off)
    );
endmodule

// File: rtl/cmb_cfg_chk.sv
`timescale 1ns/1ps
module cmb_cfg_chk
    import cmb_pkg::*;
#(
    parameter int SIZE_MB   = 4,
    parameter int CBA_SHIFT = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [11:0] wr_addr,
    input logic [63:0] wr_data,
    input logic        wr_size8,
    input logic [63:0] acc_addr,
    input logic [63:0] ctl_q,
    input logic [31:0] loc_q,
    input logic [31:0] sz_q,
    input logic [31:0] sts_q,
    input logic        win_en,
    input logic [63:0] win_base,
    input logic        hit
);
    localparam logic [63:0] SZB = 64'(SIZE_MB) << MB_SHIFT;
    localparam bit          CAP = (SIZE_MB != 0);

    logic        lo_w, hi_w, side_w, chk_wrap;
    logic [63:0] nv, nb;
    logic [64:0] ns;
    assign lo_w     = wr_en && CAP && (wr_addr == OFS_CTL_LO);
    assign hi_w     = wr_en && (wr_addr == OFS_CTL_HI);
    assign side_w   = wr_en && ((wr_addr == OFS_SZ) || (wr_addr == OFS_LOC));
    assign nv       = wr_size8 ? wr_data : {ctl_q[63:32], wr_data[31:0]};
    assign nb       = (nv >> CBA_SHIFT) << CBA_SHIFT;
    assign ns       = {1'b0, nb} + {1'b0, SZB};
    assign chk_wrap = ns[64];

    a_r9_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (win_en && acc_addr >= win_base));
    a_r5_hidden_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_w && !nv[CTL_REG_EN]) |=> (sz_q == 32'd0 && loc_q == 32'd0 && !win_en));
    a_r4_regs_shown: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_w && nv[CTL_REG_EN]) |=> (sz_q == sz_word(SIZE_MB)));
    a_r7_wrap_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_w && nv[CTL_REG_EN] && nv[CTL_MEM_EN] && chk_wrap)
            |=> (sts_q[STS_BAD_BASE] && !win_en));
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q[STS_BAD_BASE] |=> sts_q[STS_BAD_BASE]);
    a_r8_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_w && !nv[CTL_MEM_EN]) |=> !win_en);
    a_r11_side_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_w || side_w) |=> ($stable(win_en) && $stable(sz_q) && $stable(loc_q)));
endmodule

bind cmb_cfg_regs cmb_cfg_chk #(.SIZE_MB(SIZE_MB), .CBA_SHIFT(CBA_SHIFT)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_size8(wr_size8), .acc_addr(acc_addr),
    .ctl_q(ctl_q), .loc_q(loc_q), .sz_q(sz_q), .sts_q(sts_q),
    .win_en(win_en), .win_base(win_base), .hit(hit)
);

// File: tb/tb_cmb_cfg_regs.sv
`timescale 1ns/1ps
module tb_cmb_cfg_regs;
    localparam logic [63:0] SZB    = 64'h0040_0000;
    localparam logic [31:0] SZ_EXP = {20'd4, 4'd2, 3'b000, 5'b11101};
    localparam logic [31:0] LOC_EXP = 32'd2;
    localparam logic [63:0] BARB   = 64'h0000_00F0_0000_0000;

    typedef struct {
        string       tag;
        logic [63:0] ctl;
        logic [31:0] loc, sz, sts;
        logic        en, hit;
        logic [63:0] off;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_size8 = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [63:0] wr_data = '0, acc_addr = '0;
    logic [63:0] bar_base = BARB;

    logic cap_o, en_o, hit_o;
    logic [63:0] ctl_o, wb_o, off_o;
    logic [31:0] loc_o, sz_o, sts_o;
    logic cap_n, en_n, hit_n;
    logic [63:0] ctl_n, wb_n, off_n;
    logic [31:0] loc_n, sz_n, sts_n;
    logic cap_l, en_l, hit_l;
    logic [63:0] ctl_l, wb_l, off_l;
    logic [31:0] loc_l, sz_l, sts_l;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    // model state
    logic [63:0] m_ctl = '0, m_base = '0;
    logic [31:0] m_sts = '0;
    logic m_vis = 1'b0, m_en = 1'b0;

    always #10 clk = ~clk;

    cmb_cfg_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size8(wr_size8), .bar_base(bar_base),
        .acc_addr(acc_addr), .cap_o(cap_o), .ctl_q(ctl_o), .loc_q(loc_o),
        .sz_q(sz_o), .sts_q(sts_o), .win_en(en_o), .win_base(wb_o),
        .hit(hit_o), .hit_off(off_o));

    cmb_cfg_regs #(.SIZE_MB(0)) dut_nocap (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size8(wr_size8), .bar_base(bar_base),
        .acc_addr(acc_addr), .cap_o(cap_n), .ctl_q(ctl_n), .loc_q(loc_n),
        .sz_q(sz_n), .sts_q(sts_n), .win_en(en_n), .win_base(wb_n),
        .hit(hit_n), .hit_off(off_n));

    cmb_cfg_regs #(.LEGACY(1'b1)) dut_leg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size8(wr_size8), .bar_base(bar_base),
        .acc_addr(acc_addr), .cap_o(cap_l), .ctl_q(ctl_l), .loc_q(loc_l),
        .sz_q(sz_l), .sts_q(sts_l), .win_en(en_l), .win_base(wb_l),
        .hit(hit_l), .hit_off(off_l));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t mk(input string tag);
        exp_t e;
        logic [64:0] lim;
        lim = {1'b0, m_base} + {1'b0, SZB};
        e.tag = tag; e.ctl = m_ctl; e.sts = m_sts; e.en = m_en;
        e.sz  = m_vis ? SZ_EXP : 32'd0;
        e.loc = m_vis ? LOC_EXP : 32'd0;
        e.hit = m_en && (acc_addr >= m_base) && ({1'b0, acc_addr} < lim);
        e.off = acc_addr - m_base;
        return e;
    endfunction

    task automatic do_wr(input logic [11:0] a, input logic [63:0] d,
                         input logic s8, input string tag);
        logic [63:0] mv, cb;
        logic [64:0] sum;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_size8 = s8;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (a == 12'h050) begin
            mv = s8 ? d : {m_ctl[63:32], d[31:0]};
            m_ctl = mv; m_en = 1'b0;
            m_vis = mv[0];
            if (mv[0] && mv[1]) begin
                cb  = {mv[63:12], 12'h000};
                sum = {1'b0, cb} + {1'b0, SZB};
                if (sum[64]) m_sts[0] = 1'b1;
                else begin m_base = cb; m_en = 1'b1; end
            end
        end else if (a == 12'h054) begin
            m_ctl[63:32] = d[31:0];
        end
        q.push_back(mk(tag));
    endtask

    task automatic do_q(input logic [63:0] a, input string tag);
        @(negedge clk);
        acc_addr = a;
        @(posedge clk);
        #1 q.push_back(mk(tag));
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " ctl"}, ctl_o, e.ctl);
                chk({e.tag, " loc"}, 64'(loc_o), 64'(e.loc));
                chk({e.tag, " sz"},  64'(sz_o),  64'(e.sz));
                chk({e.tag, " sts"}, 64'(sts_o), 64'(e.sts));
                chk({e.tag, " en"},  64'(en_o),  64'(e.en));
                chk({e.tag, " hit"}, 64'(hit_o), 64'(e.hit));
                if (e.hit) chk({e.tag, " off"}, off_o, e.off);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        acc_addr = BARB + 64'd5;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state of the normal instance
        chk("R1 ctl", ctl_o, 64'd0);
        chk("R1 sz/loc/sts", {sz_o, loc_o | sts_o}, 64'd0);
        chk("R1 en/hit", {62'd0, en_o, hit_o}, 64'd0);
        // R10 legacy instance comes out of reset populated and live
        chk("R10 sz", 64'(sz_l), 64'(SZ_EXP));
        chk("R10 loc", 64'(loc_l), 64'(LOC_EXP));
        chk("R10 en", 64'(en_l), 64'd1);
        chk("R10 hit", 64'(hit_l), 64'd1);
        chk("R10 off", off_l, 64'd5);
        // R3 capability bit
        chk("R3 cap set", 64'(cap_o), 64'd1);
        chk("R3 cap clear", 64'(cap_n), 64'd0);

        do_wr(12'h050, 64'h0000_0000_0000_0001, 1'b0, "R4 reg enable");
        do_wr(12'h054, 64'h0000_0000_0000_0012, 1'b0, "R2 R11 high half");
        do_wr(12'h050, 64'hFFFF_FFFF_8000_0003, 1'b0, "R2 R6 low 4-byte activate");
        do_q(64'h0000_0012_8000_0000, "R9 first byte");
        do_q(64'h0000_0012_803F_FFFF, "R9 last byte");
        do_q(64'h0000_0012_8040_0000, "R9 one past end");
        do_q(64'h0000_0012_7FFF_FFFF, "R9 one below base");
        do_wr(12'h03C, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R11 size write");
        do_wr(12'h038, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R11 location write");
        do_wr(12'h054, 64'h0000_0000_0000_0077, 1'b0, "R11 high keeps window");
        do_q(64'h0000_0012_8000_0010, "R9 old base after high write");
        do_wr(12'h050, 64'hFFFF_FFFF_FFF0_0003, 1'b1, "R7 R8 wrap rejected");
        do_q(64'h0000_0012_8000_0010, "R8 window off after wrap");
        do_wr(12'h050, 64'hFFFF_FFFF_FFC0_0003, 1'b1, "R7 end exactly at top");
        do_wr(12'h050, 64'hFFFF_FFFF_FF80_0FFF, 1'b1, "R6 end just below top");
        do_q(64'hFFFF_FFFF_FFBF_FFFF, "R9 top window last byte");
        do_q(64'hFFFF_FFFF_FFC0_0000, "R9 top window past end");
        do_wr(12'h050, 64'h0000_0000_0000_0001, 1'b0, "R8 reg-only write disables");
        do_q(64'hFFFF_FFFF_FF80_0000, "R8 no hit after disable");
        do_wr(12'h050, 64'h0000_0000_0000_0002, 1'b0, "R5 reg enable clear");
        wait (q.size() == 0);
        @(negedge clk);
        // R3 instance without capability ignored every control write
        chk("R3 nocap ctl", ctl_n, 64'd0);
        chk("R3 nocap en", 64'(en_n), 64'd0);
        chk("R3 nocap sts", 64'(sts_n), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule